// File: doc/BRIEF.md
# Write-Back Direct-Mapped Cache Controller

This block is a direct-mapped, write-back cache. It sits between a small set of requesters and a slower lower memory that moves whole lines. A requester can ask for one of three things. It can read the whole line that holds an address. It can read the single word selected by the offset bits. It can write one word. The address splits into three fields, from the most significant bits down: tag, set index and word offset. Each set keeps its tag, a valid flag and a dirty flag.

Each requester sees a two-bit response code. While the cache is idle, the first requester to present an access claims it. On a tie, the lowest-numbered requester wins. Every other requester is told to wait. The owner is told it is blocked until the access completes. It then sees OK for exactly one cycle, and the cache returns to idle.

On a miss, a set holding dirty data is first written back to the lower memory. The write-back address is rebuilt from the stored tag and the set index. The set is then refilled. The access is then looked up again, so a write that missed is applied to the freshly filled line.

The lower memory takes requests over a valid/ready handshake. While the request valid is high and ready is low, the cache holds the request valid, address, direction and line unchanged. The cache takes a fill response whenever the response valid is high. The lower memory may therefore not stall that response, and it must send exactly one response for each accepted read.

The requester side has no back-pressure. A requester holds its valid and request fields steady until it sees OK, and must drop valid in the cycle it sees OK.

Top module: `wbc_cache`

## Requirements
- R1: After reset, every response is WAIT, the lower-memory request valid is low, and every set is invalid and clean. The first access to any set therefore triggers one fill and no write-back.
- R2: When idle, the lowest-numbered requester with valid high claims the cache at the next rising edge. While an owner exists, every other requester reads WAIT (code 0).
- R3: The owner reads BLOCKED (code 1) in every cycle from the claim edge until its access completes. It then reads OK (code 2) for exactly one cycle, after which all responses return to WAIT. OK never appears while a lower-memory request is pending.
- R4: An access that hits shows OK after the second rising edge counted from the first edge at which its valid was seen while idle.
- R5: A word read (op 1) returns the word at the index and offset on `rd_word`. A line read (op 0) returns all four words of the line on `rd_line`, with word k at bits [k*DW +: DW]. Both are valid in the OK cycle.
- R6: The op codes are fixed: op 0 reads a line, op 1 reads a word, op 2 writes a word. Any later read of an address returns the most recently written value.
- R7: A word write (op 2) that hits updates only that word and marks the set dirty. It makes no lower-memory request.
- R8: A miss on a clean or invalid set issues exactly one lower-memory read, with write low and address {tag, index, 0}. The new tag is installed only when the fill response arrives.
- R9: A miss on a valid dirty set first issues one write, with write high, address {stored tag, index, 0} and the current line contents. The set becomes clean when the write is accepted, and the fill read follows in the next cycle.
- R10: While the lower-memory request valid is high and ready is low, the request valid, address, direction and line stay unchanged into the next cycle.
- R11: A word write that misses performs the write-back (if the set is dirty) and the fill, and then applies the written word. A following read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester access valid, held until OK |
| req_op | input | 2*NREQ | Per-requester op: 0 line read, 1 word read, 2 word write |
| req_addr | input | AW*NREQ | Per-requester word address |
| req_wdata | input | DW*NREQ | Per-requester write data |
| resp | output | 2*NREQ | Per-requester response: 0 WAIT, 1 BLOCKED, 2 OK |
| rd_line | output | WORDS*DW | Line at the owner's index, valid with OK |
| rd_word | output | DW | Word at the owner's index and offset, valid with OK |
| mem_req_valid | output | 1 | Lower-memory request valid |
| mem_req_ready | input | 1 | Lower-memory request ready |
| mem_req_write | output | 1 | 1 for write-back, 0 for fill read |
| mem_req_addr | output | AW | Line-aligned lower-memory address |
| mem_req_line | output | WORDS*DW | Line carried by a write-back |
| mem_rsp_valid | input | 1 | Fill response valid, one pulse per accepted read |
| mem_rsp_line | input | WORDS*DW | Fill response data |

## Verification
The claim edge takes one cycle and the lookup edge takes another. A hit is therefore due as OK exactly two cycles after valid is driven, and the bench counts falling edges from the drive to assert that figure for every hit. On a miss, the OK time depends on how the lower memory stalls, so the bench only requires BLOCKED in every cycle until OK. It also counts the write-back and fill handshakes the cache issues against the counts its own tag model predicts. All inputs change on the falling edge and all outputs are read on the falling edge, half a period after the edge that updates them. A lower-memory handshake is booked at the falling edge before the rising edge that completes it.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    RSP_WAIT    = 2'd0,
    RSP_BLOCKED = 2'd1,
    RSP_OK      = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    OP_LINE_RD = 2'd0,
    OP_WORD_RD = 2'd1,
    OP_WORD_WR = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_DONE
  } st_e;

endpackage

// File: rtl/wbc_arbiter.sv
module wbc_arbiter #(
  parameter int NREQ = 2,
  parameter int IW   = 1
) (
  input  logic [NREQ-1:0] req_valid,
  output logic [IW-1:0]   grant_idx,
  output logic            grant_any
);

  // Lowest index wins; scanning downward leaves the lowest set bit last.
  always_comb begin
    grant_any = |req_valid;
    grant_idx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_valid[i]) grant_idx = IW'(i);
    end
  end

  // R2
  always_comb begin
    if (grant_any == 1'b1) begin
      grant_is_requester_chk: assert (req_valid[grant_idx] == 1'b1);
    end
  end

endmodule

// File: rtl/wbc_tagstore.sv
module wbc_tagstore #(
  parameter int SETS = 4,
  parameter int IDXW = 2,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] idx,
  input  logic            install_en,
  input  logic [TAGW-1:0] install_tag,
  input  logic            clean_en,
  input  logic            dirty_en,
  output logic            rd_valid,
  output logic [TAGW-1:0] rd_tag,
  output logic            rd_dirty
);

  logic [SETS-1:0] val_q;
  logic [SETS-1:0] dirty_q;
  logic [TAGW-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q   <= '0;
      dirty_q <= '0;
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else begin
      if (install_en) begin
        val_q[idx]   <= 1'b1;
        tag_q[idx]   <= install_tag;
        dirty_q[idx] <= 1'b0;
      end
      if (clean_en) dirty_q[idx] <= 1'b0;
      if (dirty_en) dirty_q[idx] <= 1'b1;
    end
  end

  assign rd_valid = val_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_dirty = dirty_q[idx];

  // R1
  dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~val_q) == '0);

  // R7
  dirty_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en |=> dirty_q[$past(idx)]);

endmodule

// File: rtl/wbc_datastore.sv
module wbc_datastore #(
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int DW    = 16,
  parameter int IDXW  = 2,
  parameter int OFFW  = 2
) (
  input  logic                clk,
  input  logic [IDXW-1:0]     idx,
  input  logic                line_we,
  input  logic [WORDS*DW-1:0] line_in,
  input  logic                word_we,
  input  logic [OFFW-1:0]     word_off,
  input  logic [DW-1:0]       word_in,
  output logic [WORDS*DW-1:0] line_out
);

  logic [DW-1:0] arr_q [SETS][WORDS];

  always_ff @(posedge clk) begin
    for (int k = 0; k < WORDS; k++) begin
      if (line_we) arr_q[idx][k] <= line_in[k*DW +: DW];
      else if (word_we && (word_off == OFFW'(k))) arr_q[idx][k] <= word_in;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_out
    assign line_out[g*DW +: DW] = arr_q[idx][g];
  end

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int NREQ  = 2,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int WORDS = 4,
  parameter int SETS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_valid,
  input  logic [NREQ*2-1:0]   req_op,
  input  logic [NREQ*AW-1:0]  req_addr,
  input  logic [NREQ*DW-1:0]  req_wdata,
  output logic [NREQ*2-1:0]   resp,
  output logic [WORDS*DW-1:0] rd_line,
  output logic [DW-1:0]       rd_word,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [AW-1:0]       mem_req_addr,
  output logic [WORDS*DW-1:0] mem_req_line,
  input  logic                mem_rsp_valid,
  input  logic [WORDS*DW-1:0] mem_rsp_line
);

  localparam int OFFW = $clog2(WORDS);
  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = AW - IDXW - OFFW;
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1;

  st_e            state_q, state_d;
  logic [IW-1:0]  owner_q;
  logic [AW-1:0]  addr_q;
  op_e            op_q;
  logic [DW-1:0]  wdata_q;

  logic [IW-1:0]  grant_idx;
  logic           grant_any;

  logic [IDXW-1:0] cur_idx;
  logic [TAGW-1:0] cur_tag;
  logic [OFFW-1:0] cur_off;

  logic            ts_valid, ts_dirty;
  logic [TAGW-1:0] ts_tag;
  logic            hit;
  logic            install_en, clean_en, dirty_en, word_we;
  logic [WORDS*DW-1:0] line_out;

  logic [NREQ-1:0] nonwait_vec, ok_vec;

  assign cur_idx = addr_q[OFFW +: IDXW];
  assign cur_tag = addr_q[AW-1 -: TAGW];
  assign cur_off = addr_q[OFFW-1:0];

  wbc_arbiter #(.NREQ(NREQ), .IW(IW)) u_arb (
    .req_valid (req_valid),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  wbc_tagstore #(.SETS(SETS), .IDXW(IDXW), .TAGW(TAGW)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx         (cur_idx),
    .install_en  (install_en),
    .install_tag (cur_tag),
    .clean_en    (clean_en),
    .dirty_en    (dirty_en),
    .rd_valid    (ts_valid),
    .rd_tag      (ts_tag),
    .rd_dirty    (ts_dirty)
  );

  wbc_datastore #(.SETS(SETS), .WORDS(WORDS), .DW(DW), .IDXW(IDXW), .OFFW(OFFW)) u_data (
    .clk      (clk),
    .idx      (cur_idx),
    .line_we  (install_en),
    .line_in  (mem_rsp_line),
    .word_we  (word_we),
    .word_off (cur_off),
    .word_in  (wdata_q),
    .line_out (line_out)
  );

  assign hit = ts_valid && (ts_tag == cur_tag);

  // Sequencing: lookup, optional eviction, fill, then lookup again.
  always_comb begin
    state_d    = state_q;
    install_en = 1'b0;
    clean_en   = 1'b0;
    dirty_en   = 1'b0;
    word_we    = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (grant_any) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit) begin
          if (op_q == OP_WORD_WR) begin
            word_we  = 1'b1;
            dirty_en = 1'b1;
          end
          state_d = ST_DONE;
        end else if (ts_valid && ts_dirty) begin
          state_d = ST_EVICT;
        end else begin
          state_d = ST_FILL_REQ;
        end
      end
      ST_EVICT: begin
        if (mem_req_ready) begin
          clean_en = 1'b1;
          state_d  = ST_FILL_REQ;
        end
      end
      ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
      ST_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          install_en = 1'b1;
          state_d    = ST_LOOKUP;
        end
      end
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      addr_q  <= '0;
      op_q    <= OP_LINE_RD;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && grant_any) begin
        owner_q <= grant_idx;
        addr_q  <= req_addr[grant_idx*AW +: AW];
        op_q    <= op_e'(req_op[grant_idx*2 +: 2]);
        wdata_q <= req_wdata[grant_idx*DW +: DW];
      end
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_rsp
    assign resp[g*2 +: 2] = (state_q == ST_IDLE || owner_q != IW'(g)) ? RSP_WAIT :
                            (state_q == ST_DONE) ? RSP_OK : RSP_BLOCKED;
    assign nonwait_vec[g] = (resp[g*2 +: 2] != RSP_WAIT);
    assign ok_vec[g]      = (resp[g*2 +: 2] == RSP_OK);
  end

  assign rd_line       = line_out;
  assign rd_word       = line_out[cur_off*DW +: DW];
  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FILL_REQ);
  assign mem_req_write = (state_q == ST_EVICT);
  assign mem_req_addr  = (state_q == ST_EVICT) ? {ts_tag, cur_idx, {OFFW{1'b0}}}
                                               : {cur_tag, cur_idx, {OFFW{1'b0}}};
  assign mem_req_line  = line_out;

  // R2
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nonwait_vec) <= 1);

  // R3
  release_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_vec != '0) |=> (nonwait_vec == '0));

  // R3
  no_ok_while_lower_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (ok_vec == '0));

  // R10
  lower_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_line)));

  // R9
  fill_follows_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write));

endmodule

// File: tb/test_wbc_cache.sv
`timescale 1ns/1ps
module test_wbc_cache;
  localparam int NREQ = 2, AW = 8, DW = 16, WORDS = 4, SETS = 4;
  localparam int LW = WORDS * DW;
  localparam int MEMW = 1 << AW;

  logic clk, rst_n;
  logic [NREQ-1:0]    req_valid;
  logic [NREQ*2-1:0]  req_op;
  logic [NREQ*AW-1:0] req_addr;
  logic [NREQ*DW-1:0] req_wdata;
  logic [NREQ*2-1:0]  resp;
  logic [LW-1:0]      rd_line;
  logic [DW-1:0]      rd_word;
  logic               mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0]      mem_req_addr;
  logic [LW-1:0]      mem_req_line;
  logic               mem_rsp_valid;
  logic [LW-1:0]      mem_rsp_line;

  wbc_cache #(.NREQ(NREQ), .AW(AW), .DW(DW), .WORDS(WORDS), .SETS(SETS)) i_wbc_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp(resp),
    .rd_line(rd_line), .rd_word(rd_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] mem_arr [MEMW];
  logic [DW-1:0] ref_arr [MEMW];
  bit            mv [SETS];
  logic [3:0]    mt [SETS];
  bit            md [SETS];
  int            wb_seen = 0, fill_seen = 0;
  logic [AW-1:0] exp_wb_addr, exp_fill_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] seed_word(input int a);
    return DW'(a * 37 + 5);
  endfunction

  function automatic logic [LW-1:0] ref_line(input logic [AW-1:0] base);
    logic [LW-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*DW +: DW] = ref_arr[int'(base) + k];
    return l;
  endfunction

  // Lower memory model: acts at falling edges, handshake completes at the next rising edge.
  initial begin
    bit pend = 0, stall_chk = 0, held_w;
    int dly = 0;
    logic [AW-1:0] paddr, held_a;
    logic [LW-1:0] wline;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_line  = '0;
    forever begin
      @(negedge clk);
      if (stall_chk) begin
        chk(mem_req_valid && mem_req_addr == held_a && mem_req_write == held_w,
            "R10", "request held under stall", LW'(mem_req_addr), LW'(held_a));
        stall_chk = 0;
      end
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          for (int k = 0; k < WORDS; k++) mem_rsp_line[k*DW +: DW] = mem_arr[int'(paddr) + k];
          pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && rst_n) begin
        if (!mem_req_ready) begin
          stall_chk = 1;
          held_a = mem_req_addr;
          held_w = mem_req_write;
        end else if (mem_req_write) begin
          wb_seen++;
          chk(mem_req_addr == exp_wb_addr, "R9", "write-back address",
              LW'(mem_req_addr), LW'(exp_wb_addr));
          wline = ref_line(mem_req_addr);
          chk(mem_req_line == wline, "R9", "write-back line", mem_req_line, wline);
          for (int k = 0; k < WORDS; k++)
            mem_arr[int'(mem_req_addr) + k] = mem_req_line[k*DW +: DW];
        end else begin
          fill_seen++;
          chk(mem_req_addr == exp_fill_addr, "R8", "fill address",
              LW'(mem_req_addr), LW'(exp_fill_addr));
          pend  = 1;
          dly   = $urandom % 3;
          paddr = mem_req_addr;
        end
      end
    end
  end

  task automatic predict(input logic [AW-1:0] a, output bit hit, output int ewb, output int efl);
    int ix;
    ix  = int'(a[3:2]);
    hit = mv[ix] && mt[ix] == a[7:4];
    ewb = (!hit && mv[ix] && md[ix]) ? 1 : 0;
    efl = hit ? 0 : 1;
    exp_wb_addr   = {mt[ix], a[3:2], 2'b00};
    exp_fill_addr = {a[7:4], a[3:2], 2'b00};
  endtask

  task automatic commit(input logic [AW-1:0] a, input int op, input logic [DW-1:0] wd,
                        input logic [LW-1:0] gl, input logic [DW-1:0] gw, input string req);
    int ix;
    logic [LW-1:0] el;
    ix = int'(a[3:2]);
    if (op == 0) begin
      el = ref_line({a[7:2], 2'b00});
      chk(gl == el, req, "line read data", gl, el);
    end else if (op == 1) begin
      chk(gw == ref_arr[int'(a)], req, "word read data", LW'(gw), LW'(ref_arr[int'(a)]));
    end
    if (!(mv[ix] && mt[ix] == a[7:4])) begin
      mv[ix] = 1;
      mt[ix] = a[7:4];
      md[ix] = 0;
    end
    if (op == 2) begin
      ref_arr[int'(a)] = wd;
      md[ix] = 1;
    end
  endtask

  task automatic access(input int who, input int op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input string req);
    bit hit, blk_ok;
    int ewb, efl, w0, f0, cyc;
    logic [1:0] r;
    logic [LW-1:0] gl;
    logic [DW-1:0] gw;
    string treq;
    @(negedge clk);
    predict(a, hit, ewb, efl);
    w0 = wb_seen;
    f0 = fill_seen;
    req_op[who*2 +: 2]     = 2'(op);
    req_addr[who*AW +: AW] = a;
    req_wdata[who*DW +: DW] = wd;
    req_valid[who]         = 1'b1;
    cyc = 0;
    blk_ok = 1;
    r = 2'd0;
    while (cyc < 300) begin
      @(negedge clk);
      cyc++;
      r = resp[who*2 +: 2];
      if (r == 2'd2) break;
      if (r != 2'd1) blk_ok = 0;
    end
    gl = rd_line;
    gw = rd_word;
    req_valid[who] = 1'b0;
    chk(r == 2'd2, "R3", "owner reached OK", LW'(r), LW'(2));
    chk(blk_ok, "R3", "BLOCKED until OK", LW'(blk_ok), LW'(1));
    if (hit) chk(cyc == 2, "R4", "hit latency", LW'(cyc), LW'(2));
    treq = hit ? "R7" : (ewb != 0 ? "R9" : "R8");
    chk(wb_seen - w0 == ewb, treq, "write-back count", LW'(wb_seen - w0), LW'(ewb));
    chk(fill_seen - f0 == efl, treq, "fill count", LW'(fill_seen - f0), LW'(efl));
    commit(a, op, wd, gl, gw, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit h;
    int e1, e2, cyc;
    logic [LW-1:0] gl;
    logic [DW-1:0] gw;
    void'($urandom(32'd97));
    rst_n = 1'b0;
    req_valid = '0;
    req_op = '0;
    req_addr = '0;
    req_wdata = '0;
    for (int a = 0; a < MEMW; a++) begin
      mem_arr[a] = seed_word(a);
      ref_arr[a] = seed_word(a);
    end
    for (int s = 0; s < SETS; s++) begin
      mv[s] = 0;
      mt[s] = '0;
      md[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk(resp == '0, "R1", "responses in reset", LW'(resp), LW'(0));
    chk(!mem_req_valid, "R1", "no lower request in reset", LW'(mem_req_valid), LW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(resp == '0, "R1", "responses after reset", LW'(resp), LW'(0));

    access(0, 1, 8'h10, '0, "R1");        // first touch: fill only
    access(0, 1, 8'h11, '0, "R5");        // hit word read
    access(1, 2, 8'h12, 16'hBEEF, "R7");  // write hit
    access(0, 0, 8'h10, '0, "R5");        // line read shows the written word
    access(1, 1, 8'h20, '0, "R9");        // dirty miss: write-back then fill
    access(0, 1, 8'h12, '0, "R6");        // refetch returns the written word
    access(1, 2, 8'h35, 16'h1234, "R11"); // write miss
    access(0, 1, 8'h35, '0, "R11");
    access(0, 0, 8'h34, '0, "R11");

    // R2: simultaneous requests, lowest index owns, other waits
    @(negedge clk);
    predict(8'h46, h, e1, e2);
    req_op = {2'd1, 2'd1};
    req_addr = {8'h47, 8'h46};
    req_valid = 2'b11;
    @(negedge clk);
    chk(resp[1:0] == 2'd1 && resp[3:2] == 2'd0, "R2", "tie goes to requester 0",
        LW'(resp), LW'(4'b0001));
    cyc = 0;
    while (resp[1:0] != 2'd2 && cyc < 300) begin
      chk(resp[3:2] == 2'd0, "R2", "non-owner waits", LW'(resp[3:2]), LW'(0));
      @(negedge clk);
      cyc++;
    end
    gl = rd_line;
    gw = rd_word;
    req_valid[0] = 1'b0;
    commit(8'h46, 1, '0, gl, gw, "R5");
    predict(8'h47, h, e1, e2);
    @(negedge clk);
    chk(resp == '0, "R3", "released after OK", LW'(resp), LW'(0));
    @(negedge clk);
    chk(resp[3:2] == 2'd1, "R2", "waiting requester claims next", LW'(resp[3:2]), LW'(1));
    cyc = 0;
    while (resp[3:2] != 2'd2 && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    gl = rd_line;
    gw = rd_word;
    req_valid[1] = 1'b0;
    commit(8'h47, 1, '0, gl, gw, "R2");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int who, op;
      logic [AW-1:0] a;
      who = $urandom % NREQ;
      op  = $urandom % 3;
      a   = {2'b00, 2'($urandom), 4'($urandom)};
      access(who, op, a, 16'($urandom), "R6");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule